// File: doc/BRIEF.md
# Byte-Serial Counter Host Register Front End

This block sits between an 8-bit host bus and one counter channel. It turns byte-wide bus accesses into configuration levels, single-cycle command strobes and a wide preset value for the counter core, and it hands back either a captured count or a status byte. The counter core is outside this block. The block only reads the core's live count and its flag inputs.

The host uses two ports, chosen by `bus_ctrl`. On the control port, the three most significant bits of a written byte choose a destination and the five low bits carry the payload. The four destinations are a command decoder, a mode register, an input/output register and an index register. The command decoder can do several things from one byte: reset the byte pointer, pulse one of three clear strobes, and run one of three transfers. On the data port, writes assemble the preset value one byte at a time, starting with the least significant byte. Reads return a snapshot of the count, also least significant byte first. A single byte pointer orders both kinds of data access.

Top module: `cnt_host_regs`

## Requirements
- R1: A control-port write routes its payload `bus_wdata[4:0]` by `bus_wdata[7:5]`: 000 goes to the command decoder, 001 to the mode register, 010 to the input/output register and 011 to the index register. Codes 100 through 111 change no configuration output and raise no strobe.
- R2: In a command byte, bit 0 resets the byte pointer to byte 0. Bits 2:1 select a clear action: 01 pulses `clr_count`, 10 pulses `clr_flags` and 11 pulses `clr_err`. Each pulse is high for exactly the one cycle after the clock edge that accepts the write.
- R3: In a command byte, bits 4:3 select a transfer. With 01, `load_count` pulses for one cycle, as in R2. With 10, `core_count` is captured into the read snapshot at the accepting edge. With 11, `psc_val` takes the low byte of the preset. Bit 0 and the clear field act in the same byte alongside the transfer.
- R4: Data-port writes place `bus_wdata` into the preset byte at the pointer, with byte 0 as the least significant, and then advance the pointer. After byte 2 the pointer returns to byte 0. `preset_val` shows all three bytes.
- R5: A data-port read loads `bus_rdata`, on the accepting edge, with the snapshot byte at the pointer, then advances the pointer with the same wrap as R4. The pointer is shared with writes.
- R6: A mode-register write sets `bcd_mode` from payload bit 0 (0 means binary), `count_mode` from bits 2:1 and `quad_sel` from bits 4:3 (0 = plain pulse/direction, 1/2/3 = x1/x2/x4).
- R7: An input/output write sets `ab_en` from payload bit 0. Payload bit 1 is active low, so `pidx_en` equals the inverse of that bit.
- R8: An index write sets `idx_sync` from payload bit 0 and `idx_pos` from payload bit 1 (1 = positive polarity).
- R9: A control-port read loads `bus_rdata` with `core_borrow_tgl` in bit 0, `core_carry_tgl` in bit 1, `core_err` in bit 4 and `core_up` in bit 5. All other bits are 0, and the pointer does not move.
- R10: While `rst` is high, every output is 0. The pointer is at byte 0, and the preset and snapshot are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Write access this cycle (takes precedence over bus_re) |
| bus_re | input | 1 | Read access this cycle |
| bus_ctrl | input | 1 | 1 = control/status port, 0 = data port |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Registered read byte |
| core_count | input | 24 | Live count from the core |
| core_borrow_tgl | input | 1 | Core borrow toggle flag |
| core_carry_tgl | input | 1 | Core carry toggle flag |
| core_err | input | 1 | Core error flag |
| core_up | input | 1 | Core direction flag, 1 = up |
| preset_val | output | 24 | Assembled preset value |
| psc_val | output | 8 | Filter clock prescaler value |
| clr_count | output | 1 | Strobe: clear counter |
| clr_flags | output | 1 | Strobe: clear borrow/carry/compare/sign flags |
| clr_err | output | 1 | Strobe: clear error flag |
| load_count | output | 1 | Strobe: load preset into counter |
| bcd_mode | output | 1 | 1 = BCD counting |
| count_mode | output | 2 | Count mode select |
| quad_sel | output | 2 | Quadrature select |
| ab_en | output | 1 | A/B input enable |
| pidx_en | output | 1 | Preset-on-index enable |
| idx_sync | output | 1 | Synchronous index select |
| idx_pos | output | 1 | Index polarity, 1 = positive |

## Verification
The hardest state to reach is the shared byte pointer sitting mid-sequence while the host switches between preset writes and snapshot reads. The reverse case, a command byte that resets the pointer, captures and clears all in one access, is equally hard. Directed sequences deliberately leave the pointer at bytes 1 and 2 before a wrap, a combined command or a change of direction. A long random stretch then interleaves data writes, data reads, status reads and command bytes of every target code. Through all of it, a behavioural model follows the pointer as a plain integer modulo three.

// File: rtl/cnt_regs_pkg.sv
package cnt_regs_pkg;
  localparam logic [2:0] TGT_CMD  = 3'd0;
  localparam logic [2:0] TGT_MODE = 3'd1;
  localparam logic [2:0] TGT_IO   = 3'd2;
  localparam logic [2:0] TGT_IDX  = 3'd3;

  localparam logic [1:0] ACT_CNT  = 2'd1;
  localparam logic [1:0] ACT_FLG  = 2'd2;
  localparam logic [1:0] ACT_ERR  = 2'd3;

  localparam logic [1:0] XFR_LOAD = 2'd1;
  localparam logic [1:0] XFR_SNAP = 2'd2;
  localparam logic [1:0] XFR_PSC  = 2'd3;

  typedef struct packed {
    logic clr_count;
    logic clr_flags;
    logic clr_err;
    logic load_count;
    logic load_psc;
  } core_cmd_t;

  typedef struct packed {
    logic       bcd;
    logic [1:0] cmode;
    logic [1:0] quad;
  } mode_cfg_t;

  typedef struct packed {
    logic ab_en;
    logic pidx_n;
  } io_cfg_t;

  typedef struct packed {
    logic sync;
    logic pos;
  } idx_cfg_t;
endpackage

// File: rtl/cnt_cmd_decode.sv
module cnt_cmd_decode
  import cnt_regs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              ctrl_we,
  input  logic [DATA_W-1:0] ctrl_byte,
  output logic              ptr_clr,
  output logic              snap_req,
  output core_cmd_t         cmd,
  output logic              mode_we,
  output logic              io_we,
  output logic              idx_we,
  output logic [4:0]        payload
);
  logic [2:0] tgt;
  logic [1:0] act;
  logic [1:0] xfr;
  logic       is_cmd;

  assign tgt     = ctrl_byte[DATA_W-1 -: 3];
  assign payload = ctrl_byte[4:0];
  assign act     = payload[2:1];
  assign xfr     = payload[4:3];
  assign is_cmd  = ctrl_we && (tgt == TGT_CMD);

  always_comb begin
    mode_we        = ctrl_we && (tgt == TGT_MODE);
    io_we          = ctrl_we && (tgt == TGT_IO);
    idx_we         = ctrl_we && (tgt == TGT_IDX);
    ptr_clr        = is_cmd && payload[0];
    snap_req       = is_cmd && (xfr == XFR_SNAP);
    cmd            = '0;
    cmd.clr_count  = is_cmd && (act == ACT_CNT);
    cmd.clr_flags  = is_cmd && (act == ACT_FLG);
    cmd.clr_err    = is_cmd && (act == ACT_ERR);
    cmd.load_count = is_cmd && (xfr == XFR_LOAD);
    cmd.load_psc   = is_cmd && (xfr == XFR_PSC);
  end
endmodule

// File: rtl/cnt_cfg_regs.sv
module cnt_cfg_regs
  import cnt_regs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_we,
  input  logic       io_we,
  input  logic       idx_we,
  input  logic [4:0] payload,
  output mode_cfg_t  mode_q,
  output io_cfg_t    io_q,
  output idx_cfg_t   idx_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      io_q   <= '{ab_en: 1'b0, pidx_n: 1'b1};
      idx_q  <= '0;
    end else begin
      if (mode_we) begin
        mode_q.bcd   <= payload[0];
        mode_q.cmode <= payload[2:1];
        mode_q.quad  <= payload[4:3];
      end
      if (io_we) begin
        io_q.ab_en  <= payload[0];
        io_q.pidx_n <= payload[1];
      end
      if (idx_we) begin
        idx_q.sync <= payload[0];
        idx_q.pos  <= payload[1];
      end
    end
  end
endmodule

// File: rtl/cnt_byte_window.sv
module cnt_byte_window #(
  parameter int DATA_W = 8,
  parameter int NBYTES = 3,
  localparam int TOT_W = DATA_W * NBYTES,
  localparam int PTR_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              data_we,
  input  logic              data_re,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ptr_clr,
  input  logic              snap_req,
  input  logic [TOT_W-1:0]  core_count,
  output logic [TOT_W-1:0]  preset_flat,
  output logic [DATA_W-1:0] rd_byte
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NBYTES - 1);

  logic [PTR_W-1:0]  ptr_q;
  logic [DATA_W-1:0] preset_q [NBYTES];
  logic [DATA_W-1:0] snap_q   [NBYTES];

  always_ff @(posedge clk) begin
    if (rst || ptr_clr) begin
      ptr_q <= '0;
    end else if (data_we || data_re) begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst) begin
        preset_q[g] <= '0;
        snap_q[g]   <= '0;
      end else begin
        if (data_we && (ptr_q == PTR_W'(g))) preset_q[g] <= wdata;
        if (snap_req) snap_q[g] <= core_count[g*DATA_W +: DATA_W];
      end
    end
    assign preset_flat[g*DATA_W +: DATA_W] = preset_q[g];
  end

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < NBYTES; i++) begin
      if (ptr_q == PTR_W'(i)) rd_byte = snap_q[i];
    end
  end
endmodule

// File: rtl/cnt_host_regs.sv
module cnt_host_regs
  import cnt_regs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NBYTES = 3,
  localparam int TOT_W = DATA_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic              bus_ctrl,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [TOT_W-1:0]  core_count,
  input  logic              core_borrow_tgl,
  input  logic              core_carry_tgl,
  input  logic              core_err,
  input  logic              core_up,
  output logic [TOT_W-1:0]  preset_val,
  output logic [DATA_W-1:0] psc_val,
  output logic              clr_count,
  output logic              clr_flags,
  output logic              clr_err,
  output logic              load_count,
  output logic              bcd_mode,
  output logic [1:0]        count_mode,
  output logic [1:0]        quad_sel,
  output logic              ab_en,
  output logic              pidx_en,
  output logic              idx_sync,
  output logic              idx_pos
);
  logic              ctrl_we, data_we, data_re, stat_re;
  logic              ptr_clr, snap_req, mode_we, io_we, idx_we;
  logic [4:0]        payload;
  core_cmd_t         cmd;
  core_cmd_t         cmd_q;
  mode_cfg_t         mode_q;
  io_cfg_t           io_q;
  idx_cfg_t          idx_q;
  logic [DATA_W-1:0] win_byte;
  logic [DATA_W-1:0] status_byte;

  assign ctrl_we = bus_we && bus_ctrl;
  assign data_we = bus_we && !bus_ctrl;
  assign data_re = bus_re && !bus_we && !bus_ctrl;
  assign stat_re = bus_re && !bus_we && bus_ctrl;

  cnt_cmd_decode #(.DATA_W(DATA_W)) u_dec (
    .ctrl_we  (ctrl_we),
    .ctrl_byte(bus_wdata),
    .ptr_clr  (ptr_clr),
    .snap_req (snap_req),
    .cmd      (cmd),
    .mode_we  (mode_we),
    .io_we    (io_we),
    .idx_we   (idx_we),
    .payload  (payload)
  );

  cnt_cfg_regs u_cfg (
    .clk    (clk),
    .rst    (rst),
    .mode_we(mode_we),
    .io_we  (io_we),
    .idx_we (idx_we),
    .payload(payload),
    .mode_q (mode_q),
    .io_q   (io_q),
    .idx_q  (idx_q)
  );

  cnt_byte_window #(.DATA_W(DATA_W), .NBYTES(NBYTES)) u_win (
    .clk        (clk),
    .rst        (rst),
    .data_we    (data_we),
    .data_re    (data_re),
    .wdata      (bus_wdata),
    .ptr_clr    (ptr_clr),
    .snap_req   (snap_req),
    .core_count (core_count),
    .preset_flat(preset_val),
    .rd_byte    (win_byte)
  );

  always_comb begin
    status_byte    = '0;
    status_byte[0] = core_borrow_tgl;
    status_byte[1] = core_carry_tgl;
    status_byte[4] = core_err;
    status_byte[5] = core_up;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q     <= '0;
      psc_val   <= '0;
      bus_rdata <= '0;
    end else begin
      cmd_q <= cmd;
      if (cmd.load_psc) psc_val <= preset_val[DATA_W-1:0];
      if (stat_re)      bus_rdata <= status_byte;
      else if (data_re) bus_rdata <= win_byte;
    end
  end

  assign clr_count  = cmd_q.clr_count;
  assign clr_flags  = cmd_q.clr_flags;
  assign clr_err    = cmd_q.clr_err;
  assign load_count = cmd_q.load_count;
  assign bcd_mode   = mode_q.bcd;
  assign count_mode = mode_q.cmode;
  assign quad_sel   = mode_q.quad;
  assign ab_en      = io_q.ab_en;
  assign pidx_en    = !io_q.pidx_n;
  assign idx_sync   = idx_q.sync;
  assign idx_pos    = idx_q.pos;
endmodule

// File: rtl/cnt_host_regs_chk.sv
module cnt_host_regs_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic              bus_re,
  input logic              bus_ctrl,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              clr_count,
  input logic              clr_flags,
  input logic              clr_err,
  input logic              load_count,
  input logic              bcd_mode,
  input logic [1:0]        count_mode,
  input logic [1:0]        quad_sel,
  input logic              ab_en,
  input logic              pidx_en,
  input logic              idx_sync,
  input logic              idx_pos
);
  logic [8:0] cfg_vec;
  assign cfg_vec = {bcd_mode, count_mode, quad_sel, ab_en, pidx_en, idx_sync, idx_pos};

  p_clr_count_src_r2: assert property (@(posedge clk) disable iff (rst)
    clr_count |-> $past(bus_we && bus_ctrl && bus_wdata[7:5] == 3'd0 && bus_wdata[2:1] == 2'd1));

  p_clr_err_src_r2: assert property (@(posedge clk) disable iff (rst)
    clr_err |-> $past(bus_we && bus_ctrl && bus_wdata[7:5] == 3'd0 && bus_wdata[2:1] == 2'd3));

  p_load_src_r3: assert property (@(posedge clk) disable iff (rst)
    load_count |-> $past(bus_we && bus_ctrl && bus_wdata[7:5] == 3'd0 && bus_wdata[4:3] == 2'd1));

  p_clear_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({clr_count, clr_flags, clr_err}));

  p_cfg_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_ctrl) |=> $stable(cfg_vec));

  p_high_tgt_ignored_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_ctrl && bus_wdata[7]) |=>
      ($stable(cfg_vec) && !clr_count && !clr_flags && !clr_err && !load_count));

  p_pidx_inverted_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_ctrl && bus_wdata[7:5] == 3'd2) |=> (pidx_en == !$past(bus_wdata[1])));

  p_status_unused_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_re && !bus_we && bus_ctrl) |=> (bus_rdata[7:6] == 2'b00 && bus_rdata[3:2] == 2'b00));
endmodule

bind cnt_host_regs cnt_host_regs_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/cnt_host_regs_bench.sv
`timescale 1ns/1ps
module cnt_host_regs_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0, bus_re = 1'b0, bus_ctrl = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [23:0] core_count = '0;
  logic        core_borrow_tgl = 1'b0, core_carry_tgl = 1'b0, core_err = 1'b0, core_up = 1'b0;
  logic [23:0] preset_val;
  logic [7:0]  psc_val;
  logic        clr_count, clr_flags, clr_err, load_count;
  logic        bcd_mode, ab_en, pidx_en, idx_sync, idx_pos;
  logic [1:0]  count_mode, quad_sel;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cnt_host_regs u_cnt_host_regs (.*);

  // behavioural reference model
  int         m_ptr;
  logic [7:0] m_pre [3];
  logic [7:0] m_snap [3];
  logic [7:0] m_rd, m_psc;
  logic       m_cc, m_cf, m_ce, m_ld;
  logic [4:0] m_mode;
  logic [1:0] m_io, m_idx;
  bit         m_live = 1'b0;

  always @(posedge clk) begin
    cycles++;
    m_cc = 0; m_cf = 0; m_ce = 0; m_ld = 0;
    if (rst) begin
      m_ptr = 0; m_rd = 0; m_psc = 0; m_mode = 0; m_io = 2'b10; m_idx = 0;
      for (int i = 0; i < 3; i++) begin m_pre[i] = 0; m_snap[i] = 0; end
    end else if (bus_we && bus_ctrl) begin
      case (bus_wdata[7:5])
        3'd0: begin
          if (bus_wdata[2:1] == 1) m_cc = 1;
          if (bus_wdata[2:1] == 2) m_cf = 1;
          if (bus_wdata[2:1] == 3) m_ce = 1;
          if (bus_wdata[4:3] == 1) m_ld = 1;
          if (bus_wdata[4:3] == 2)
            for (int i = 0; i < 3; i++) m_snap[i] = core_count[8*i +: 8];
          if (bus_wdata[4:3] == 3) m_psc = m_pre[0];
          if (bus_wdata[0]) m_ptr = 0;
        end
        3'd1: m_mode = bus_wdata[4:0];
        3'd2: m_io = bus_wdata[1:0];
        3'd3: m_idx = bus_wdata[1:0];
        default: ;
      endcase
    end else if (bus_we) begin
      m_pre[m_ptr] = bus_wdata;
      m_ptr = (m_ptr + 1) % 3;
    end else if (bus_re && bus_ctrl) begin
      m_rd = {2'b00, core_up, core_err, 2'b00, core_carry_tgl, core_borrow_tgl};
    end else if (bus_re) begin
      m_rd = m_snap[m_ptr];
      m_ptr = (m_ptr + 1) % 3;
    end
    m_live = 1'b1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (m_live && !done) begin
      chk("R5/R9 bus_rdata", bus_rdata, m_rd);
      chk("R4 preset_val", preset_val, {m_pre[2], m_pre[1], m_pre[0]});
      chk("R3 psc_val", psc_val, m_psc);
      chk("R2/R3 strobes", {clr_count, clr_flags, clr_err, load_count}, {m_cc, m_cf, m_ce, m_ld});
      chk("R6 mode", {quad_sel, count_mode, bcd_mode}, {m_mode[4:3], m_mode[2:1], m_mode[0]});
      chk("R7 io", {pidx_en, ab_en}, {~m_io[1], m_io[0]});
      chk("R8 idx", {idx_pos, idx_sync}, m_idx);
    end
  end

  task automatic ctrl_wr(input logic [7:0] b);
    @(negedge clk); bus_we = 1; bus_ctrl = 1; bus_wdata = b;
    @(negedge clk); bus_we = 0;
  endtask
  task automatic data_wr(input logic [7:0] b);
    @(negedge clk); bus_we = 1; bus_ctrl = 0; bus_wdata = b;
    @(negedge clk); bus_we = 0;
  endtask
  task automatic rd(input logic ctrl);
    @(negedge clk); bus_re = 1; bus_ctrl = ctrl;
    @(negedge clk); bus_re = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10 rdata", bus_rdata, 0);
    chk("R10 preset", preset_val, 0);
    chk("R10 strobes", {clr_count, clr_flags, clr_err, load_count}, 0);
    chk("R10 cfg", {bcd_mode, count_mode, quad_sel, ab_en, pidx_en, idx_sync, idx_pos}, 0);
    rst = 0;
    @(negedge clk);

    ctrl_wr(8'b001_11101);
    chk("R6 quad", quad_sel, 3); chk("R6 cmode", count_mode, 2); chk("R6 bcd", bcd_mode, 1);
    ctrl_wr(8'b010_00010);
    chk("R7 ab off", ab_en, 0); chk("R7 pidx off", pidx_en, 0);
    ctrl_wr(8'b010_00001);
    chk("R7 ab on", ab_en, 1); chk("R7 pidx on", pidx_en, 1);
    ctrl_wr(8'b011_00010);
    chk("R8 sync", idx_sync, 0); chk("R8 pos", idx_pos, 1);
    for (int t = 4; t < 8; t++) begin
      ctrl_wr({3'(t), 5'b11111});
      chk("R1 ignored cfg", {bcd_mode, count_mode, quad_sel, ab_en, pidx_en, idx_sync, idx_pos},
          {1'b1, 2'd2, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1});
      chk("R1 ignored strobes", {clr_count, clr_flags, clr_err, load_count}, 0);
    end

    data_wr(8'h12); data_wr(8'h34); data_wr(8'h56);
    chk("R4 preset three bytes", preset_val, 24'h563412);
    data_wr(8'h9A);
    chk("R4 wrap to byte 0", preset_val, 24'h56349A);
    ctrl_wr(8'h18);
    chk("R3 prescaler from preset LSB", psc_val, 8'h9A);
    data_wr(8'h77);
    chk("R4 pointer kept at byte 1", preset_val, 24'h56779A);
    ctrl_wr(8'h01);
    data_wr(8'hC3);
    chk("R2 pointer reset", preset_val, 24'h5677C3);

    ctrl_wr(8'h02);
    chk("R2 clr_count pulse", clr_count, 1);
    @(negedge clk);
    chk("R2 clr_count one cycle", clr_count, 0);
    ctrl_wr(8'h04); chk("R2 clr_flags pulse", clr_flags, 1);
    ctrl_wr(8'h06); chk("R2 clr_err pulse", clr_err, 1);
    ctrl_wr(8'h08); chk("R3 load pulse", load_count, 1);
    ctrl_wr(8'h0F);
    chk("R3 combined load+clr_err", {load_count, clr_err}, 2'b11);

    core_count = 24'hABCDEF;
    ctrl_wr(8'h11);
    core_count = 24'h000000;
    rd(0); chk("R5 byte0", bus_rdata, 8'hEF);
    rd(0); chk("R5 byte1", bus_rdata, 8'hCD);
    rd(0); chk("R5 byte2", bus_rdata, 8'hAB);
    rd(0); chk("R5 wrap", bus_rdata, 8'hEF);

    core_borrow_tgl = 1; core_carry_tgl = 0; core_err = 1; core_up = 1;
    rd(1); chk("R9 status", bus_rdata, 8'h31);
    rd(0); chk("R9 status read leaves pointer", bus_rdata, 8'hCD);

    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      core_count = $urandom;
      {core_borrow_tgl, core_carry_tgl, core_err, core_up} = 4'($urandom);
      bus_we = 0; bus_re = 0;
      case ($urandom % 5)
        0: begin bus_we = 1; bus_ctrl = 1; bus_wdata = 8'($urandom); end
        1: begin bus_we = 1; bus_ctrl = 0; bus_wdata = 8'($urandom); end
        2: begin bus_re = 1; bus_ctrl = 0; end
        3: begin bus_re = 1; bus_ctrl = 1; end
        default: ;
      endcase
    end
    @(negedge clk); bus_we = 0; bus_re = 0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule